// File: doc/BRIEF.md
# Dual-Mode Microprocessor Bus Interface

This block lets an external processor reach an on-chip register file over an asynchronous parallel bus. A static mode pin selects one of two bus conventions. In one, separate active-low read and write strobes are used with an active-high address latch. In the other, a single active-low data strobe is used with a read/write level and an active-low address strobe. The 9-bit address is captured while the latch/strobe input is active and is held once that input goes inactive.

The bus strobes and chip select are passed through a synchronizer into the core clock domain before any register access starts. A single shared handshake output paces the processor. In the first convention it is a READY line that is pulled low to stretch the cycle and raised when the cycle may complete. In the second it is an active-low acknowledge, and it is held back until the access is finished. A wait request from the register file lengthens the cycle in either mode. The data bus is modelled as separate input and output buses with an output enable.

Top module: `mpbus_if`

## Requirements
- R1: The address latch input is active high when `bus_mode_i`=0 and active low when `bus_mode_i`=1. While it is active, `reg_addr_o` follows `addr_i` one clock later. While it is inactive, `reg_addr_o` holds its value.
- R2: With `bus_mode_i`=0 and `cs_n_i`=0, `strb_n_i`=0 requests a read and `dir_i`=0 requests a write.
- R3: With `bus_mode_i`=1 and `cs_n_i`=0, `strb_n_i`=0 requests an access. `dir_i`=1 selects a read and `dir_i`=0 selects a write.
- R4: While `cs_n_i`=1, strobes start no register access, no write reaches the register file, and `hs_o` stays at its idle level (high).
- R5: Register access (`reg_rd_o` or `reg_wr_o`) starts on the third rising clock edge after a strobe becomes active. With `reg_wait_i` low, the handshake signals completion on the fourth edge.
- R6: While an access is pending and `reg_wait_i`=1, `hs_o` is low in mode 0 and high in mode 1. Completion follows on the first edge at which `reg_wait_i` is low.
- R7: On a read, `data_o` carries the addressed register value no later than the handshake signals completion. `data_oe_o` is high only while chip select and a read strobe are both active.
- R8: On a write, the value on `data_i` is written to the addressed register exactly once per bus cycle. A write commits on a clock edge where `reg_wr_o`=1 and `reg_wait_i`=0.
- R9: When the strobes are released, `hs_o` returns high at once. No new access starts until a strobe is asserted again.
- R10: In mode 0, `hs_o` goes low as soon as chip select and a strobe are active. It stays low until completion.
- R11: After reset, `hs_o` is high, `data_oe_o` is low and no register access is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode_i | input | 1 | 0: separate read/write strobes; 1: data strobe with read/write level |
| cs_n_i | input | 1 | Chip select, active low |
| ale_as_i | input | 1 | Address latch (mode 0, active high) or address strobe (mode 1, active low) |
| addr_i | input | ADDR_W | Processor address bus |
| data_i | input | DATA_W | Processor write data |
| data_o | output | DATA_W | Read data toward the processor |
| data_oe_o | output | 1 | Drive enable for the data bus |
| strb_n_i | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| dir_i | input | 1 | Write strobe active low (mode 0) or read/write level (mode 1) |
| hs_o | output | 1 | READY (mode 0) or acknowledge, active low (mode 1) |
| reg_addr_o | output | ADDR_W | Register file address |
| reg_wdata_o | output | DATA_W | Register file write data |
| reg_rd_o | output | 1 | Register read request |
| reg_wr_o | output | 1 | Register write request |
| reg_rdata_i | input | DATA_W | Register file read data |
| reg_wait_i | input | 1 | Register file wait request |

## Verification
The bench builds the block with its defaults: a 9-bit address, an 8-bit data path and two synchronizer stages. The full address space is therefore reachable, including the top address 0x1FF. The two-stage setting makes the completion latency exactly four edges with no wait, and one edge after the wait request drops when waits are longer. These exact latencies are what the bench checks in both bus conventions.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;

    typedef enum logic {
        BUS_SPLIT  = 1'b0,
        BUS_STROBE = 1'b1
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_DONE   = 2'd2
    } cyc_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } bus_req_t;

    // Turns raw pin levels into read/write requests for the selected convention.
    function automatic bus_req_t decode_req(bus_mode_e mode, logic cs_n,
                                            logic strb_n, logic dir);
        bus_req_t r;
        r.rd = 1'b0;
        r.wr = 1'b0;
        if (!cs_n) begin
            if (mode == BUS_SPLIT) begin
                r.rd = !strb_n;
                r.wr = !dir;
            end else if (!strb_n) begin
                r.rd = dir;
                r.wr = !dir;
            end
        end
        return r;
    endfunction

    // Address capture polarity depends on the convention.
    function automatic logic latch_open(bus_mode_e mode, logic ale_as);
        return (mode == BUS_SPLIT) ? ale_as : !ale_as;
    endfunction

endpackage

// File: rtl/mpbus_sync.sv
module mpbus_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= RST_VAL;
                else     chain_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= RST_VAL;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpbus_addr_latch.sv
module mpbus_addr_latch #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk) begin
        if (rst)         addr_o <= '0;
        else if (open_i) addr_o <= addr_i;
    end
endmodule

// File: rtl/mpbus_ctrl.sv
module mpbus_ctrl
    import mpbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_mode_e         mode_i,
    input  bus_req_t          sync_req_i,
    input  bus_req_t          raw_req_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic              reg_wait_i,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic [DATA_W-1:0] data_o,
    output logic              hs_o
);
    cyc_state_e        state_q;
    logic              is_wr_q;
    logic              sync_act;
    logic              raw_act;
    logic              done;

    assign sync_act = sync_req_i.rd | sync_req_i.wr;
    assign raw_act  = raw_req_i.rd | raw_req_i.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            is_wr_q     <= 1'b0;
            reg_wdata_o <= '0;
            data_o      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sync_act) begin
                        state_q <= ST_ACCESS;
                        is_wr_q <= sync_req_i.wr;
                        if (sync_req_i.wr) reg_wdata_o <= data_i;
                    end
                end
                ST_ACCESS: begin
                    if (!reg_wait_i) begin
                        if (!is_wr_q) data_o <= reg_rdata_i;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (!sync_act) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign reg_rd_o = (state_q == ST_ACCESS) && !is_wr_q;
    assign reg_wr_o = (state_q == ST_ACCESS) &&  is_wr_q;
    assign done     = (state_q == ST_DONE);

    always_comb begin
        if (mode_i == BUS_SPLIT) hs_o = !raw_act || done;
        else                     hs_o = !(raw_act && done);
    end
endmodule

// File: rtl/mpbus_if.sv
module mpbus_if
    import mpbus_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_mode_i,
    input  logic              cs_n_i,
    input  logic              ale_as_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    input  logic              strb_n_i,
    input  logic              dir_i,
    output logic              hs_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic              reg_wait_i
);
    localparam int PIN_W = 3;

    bus_mode_e         mode;
    bus_req_t          raw_req;
    bus_req_t          sync_req;
    logic [PIN_W-1:0]  pins_sync;

    assign mode    = bus_mode_e'(bus_mode_i);
    assign raw_req = decode_req(mode, cs_n_i, strb_n_i, dir_i);

    mpbus_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({PIN_W{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({cs_n_i, strb_n_i, dir_i}),
        .q_o (pins_sync)
    );

    assign sync_req = decode_req(mode, pins_sync[2], pins_sync[1], pins_sync[0]);

    mpbus_addr_latch #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk    (clk),
        .rst    (rst),
        .open_i (latch_open(mode, ale_as_i)),
        .addr_i (addr_i),
        .addr_o (reg_addr_o)
    );

    mpbus_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .sync_req_i  (sync_req),
        .raw_req_i   (raw_req),
        .data_i      (data_i),
        .reg_rdata_i (reg_rdata_i),
        .reg_wait_i  (reg_wait_i),
        .reg_rd_o    (reg_rd_o),
        .reg_wr_o    (reg_wr_o),
        .reg_wdata_o (reg_wdata_o),
        .data_o      (data_o),
        .hs_o        (hs_o)
    );

    assign data_oe_o = raw_req.rd;
endmodule

// File: rtl/mpbus_if_chk.sv
module mpbus_if_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_mode_i,
    input logic              cs_n_i,
    input logic              strb_n_i,
    input logic              dir_i,
    input logic              data_oe_o,
    input logic              hs_o,
    input logic [DATA_W-1:0] reg_wdata_o,
    input logic              reg_rd_o,
    input logic              reg_wr_o,
    input logic              reg_wait_i
);
    // R11: reset leaves the register port idle
    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (!reg_rd_o && !reg_wr_o));

    // R2 / R3: a cycle is either a read or a write
    a_r2_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_o && reg_wr_o));

    // R6: split-strobe mode keeps READY low while waiting
    a_r6_wait_ready_low: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode_i && (reg_rd_o || reg_wr_o) && reg_wait_i && !cs_n_i
         && (!strb_n_i || !dir_i)) |-> !hs_o);

    // R6: strobe mode never acknowledges during a pending access
    a_r6_wait_ack_held: assert property (@(posedge clk) disable iff (rst)
        (bus_mode_i && (reg_rd_o || reg_wr_o)) |-> hs_o);

    // R8: exactly one commit per write cycle
    a_r8_single_commit: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_o && !reg_wait_i) |=> !reg_wr_o);

    // R8: write data stays put while the write is pending
    a_r8_wdata_stable: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_o && $past(reg_wr_o)) |-> $stable(reg_wdata_o));

    // R7: bus drive needs chip select
    a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> !cs_n_i);

    // R9: acknowledge released with the data strobe
    a_r9_ack_released: assert property (@(posedge clk) disable iff (rst)
        (bus_mode_i && strb_n_i) |-> hs_o);
endmodule

bind mpbus_if mpbus_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mpbus_if_tb.sv
`timescale 1ns/1ps
module mpbus_if_tb;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;
    localparam int SYNC   = 2;
    localparam int LAT0   = SYNC + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_mode_i = 1'b0;
    logic              cs_n_i = 1'b1;
    logic              ale_as_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] data_i = '0;
    logic [DATA_W-1:0] data_o;
    logic              data_oe_o;
    logic              strb_n_i = 1'b1;
    logic              dir_i = 1'b1;
    logic              hs_o;
    logic [ADDR_W-1:0] reg_addr_o;
    logic [DATA_W-1:0] reg_wdata_o;
    logic              reg_rd_o;
    logic              reg_wr_o;
    logic [DATA_W-1:0] reg_rdata_i;
    logic              reg_wait_i = 1'b0;

    int n_checks = 0;
    int n_err    = 0;
    int wr_commits = 0;
    logic [DATA_W-1:0] mem [1 << ADDR_W];

    always #5 clk = ~clk;

    mpbus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) u_dut (.*);

    assign reg_rdata_i = mem[reg_addr_o];
    always @(posedge clk) begin
        if (!rst && reg_wr_o && !reg_wait_i) begin
            mem[reg_addr_o] <= reg_wdata_o;
            wr_commits <= wr_commits + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        bus_mode_i = m;
        ale_as_i   = m;
        cs_n_i     = 1'b1;
        strb_n_i   = 1'b1;
        dir_i      = 1'b1;
        repeat (SYNC + 3) @(negedge clk);
    endtask

    // One processor cycle; checks handshake, latency, read data, commits.
    task automatic bus_cycle(input logic is_wr, input logic [ADDR_W-1:0] addr,
                             input logic [DATA_W-1:0] wdata, input int waits,
                             input logic [DATA_W-1:0] exp_rd, input string tag);
        int base;
        int lat;
        int exp_lat;
        logic fin;
        @(negedge clk);
        ale_as_i = !bus_mode_i;
        addr_i   = addr;
        @(negedge clk);
        if (!bus_mode_i) ale_as_i = 1'b0;
        reg_wait_i = (waits > 0);
        base   = wr_commits;
        cs_n_i = 1'b0;
        data_i = wdata;
        if (bus_mode_i) begin
            dir_i = !is_wr;
            strb_n_i = 1'b0;
        end else if (is_wr) dir_i = 1'b0;
        else strb_n_i = 1'b0;
        #1;
        if (!bus_mode_i) chk({tag, " R10 ready low at strobe"}, hs_o, 0);
        lat = 0;
        fin = 1'b0;
        while (!fin && lat < 60) begin
            @(negedge clk);
            lat++;
            fin = bus_mode_i ? !hs_o : hs_o;
            if (reg_wait_i && fin) chk({tag, " R6 completed during wait"}, lat, -1);
            if (lat >= waits) reg_wait_i = 1'b0;
        end
        exp_lat = (waits + 1 > LAT0) ? waits + 1 : LAT0;
        chk({tag, " R5 R6 completion latency"}, lat, exp_lat);
        if (!is_wr) begin
            chk({tag, " R7 read data"}, data_o, exp_rd);
            chk({tag, " R7 data drive enable"}, data_oe_o, 1);
        end else begin
            chk({tag, " R7 no drive on write"}, data_oe_o, 0);
        end
        cs_n_i = 1'b1;
        strb_n_i = 1'b1;
        dir_i = 1'b1;
        if (bus_mode_i) ale_as_i = 1'b1;
        #1;
        chk({tag, " R9 handshake idle on release"}, hs_o, 1);
        repeat (SYNC + 3) begin
            @(negedge clk);
            if (reg_rd_o || reg_wr_o) chk({tag, " R9 access after release"}, 1, 0);
        end
        chk({tag, " R8 commit count"}, wr_commits - base, is_wr ? 1 : 0);
        if (is_wr) chk({tag, " R8 register value"}, mem[addr], wdata);
    endtask

    task automatic t_reset;
        chk("R11 hs after reset", hs_o, 1);
        chk("R11 oe after reset", data_oe_o, 0);
        chk("R11 rd after reset", reg_rd_o, 0);
        chk("R11 wr after reset", reg_wr_o, 0);
    endtask

    task automatic t_split_mode;
        set_mode(1'b0);
        bus_cycle(1'b1, 9'h1A5, 8'h3C, 0, 8'h00, "R2 write");
        bus_cycle(1'b0, 9'h1A5, 8'h00, 0, 8'h3C, "R2 read");
        bus_cycle(1'b0, 9'h003, 8'h00, 0, 8'h5A, "R2 read preset");
        bus_cycle(1'b0, 9'h1FF, 8'h00, 7, 8'hE1, "R6 read wait");
        bus_cycle(1'b1, 9'h010, 8'h77, 5, 8'h00, "R6 write wait");
    endtask

    task automatic t_strobe_mode;
        set_mode(1'b1);
        bus_cycle(1'b1, 9'h0FF, 8'h81, 0, 8'h00, "R3 write");
        bus_cycle(1'b0, 9'h0FF, 8'h00, 0, 8'h81, "R3 read");
        bus_cycle(1'b1, 9'h100, 8'hC3, 9, 8'h00, "R6 strobe write wait");
        bus_cycle(1'b0, 9'h100, 8'h00, 6, 8'hC3, "R6 strobe read wait");
    endtask

    task automatic t_no_select(input logic m);
        int base;
        set_mode(m);
        mem[9'h044] = 8'h11;
        @(negedge clk);
        ale_as_i = !m;
        addr_i = 9'h044;
        @(negedge clk);
        if (!m) ale_as_i = 1'b0;
        base = wr_commits;
        data_i = 8'hEE;
        dir_i = 1'b0;
        strb_n_i = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (!hs_o || reg_rd_o || reg_wr_o || data_oe_o)
                chk("R4 activity without select", 1, 0);
        end
        chk("R4 no commit", wr_commits - base, 0);
        chk("R4 register untouched", mem[9'h044], 8'h11);
        strb_n_i = 1'b1;
        dir_i = 1'b1;
        if (m) ale_as_i = 1'b1;
    endtask

    task automatic t_addr_latch;
        set_mode(1'b0);
        @(negedge clk);
        ale_as_i = 1'b1;
        addr_i = 9'h0AB;
        @(negedge clk);
        chk("R1 split latch follows", reg_addr_o, 9'h0AB);
        ale_as_i = 1'b0;
        addr_i = 9'h154;
        repeat (3) @(negedge clk);
        chk("R1 split latch holds", reg_addr_o, 9'h0AB);
        set_mode(1'b1);
        addr_i = 9'h0C0;
        repeat (2) @(negedge clk);
        chk("R1 strobe mode holds when high", reg_addr_o, 9'h0AB);
        ale_as_i = 1'b0;
        @(negedge clk);
        chk("R1 strobe mode follows when low", reg_addr_o, 9'h0C0);
        ale_as_i = 1'b1;
        addr_i = 9'h1E0;
        repeat (2) @(negedge clk);
        chk("R1 strobe mode holds again", reg_addr_o, 9'h0C0);
    endtask

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = DATA_W'(i * 7 + 'h41);
        mem[9'h003] = 8'h5A;
        mem[9'h1FF] = 8'hE1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_split_mode();
        t_strobe_mode();
        t_no_select(1'b0);
        t_no_select(1'b1);
        t_addr_latch();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #1500000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule